// File: doc/BRIEF.md
# Video-mode display-link packet sequencer

This block generates the complete byte-level packet stream for a serial display link running in non-burst video mode with sync events. Software-visible timing counts set the frame geometry: active width, front porch, sync width and back porch in pixels, plus vertical front porch, back porch and active line counts. From these it emits each packet with its header, ECC, payload and CRC, one byte per clock. Strobes mark the first and last byte of every high-speed burst for the lane serializer that follows. Between bursts the lane sits in the low-power stop state.

Every vertical-interval line is sent as its own short burst. The whole active region is sent as one long burst that spans all active lines. Pixels are pulled from a simple 24-bit input, one pixel per three payload bytes. Three static controls set the variants. The first picks the porch filler type. The second appends an end-of-transmission packet to each burst. The third adds front-porch filler to the vertical-interval bursts. Frames repeat back to back with no gap.

Typical timing is 376 active pixels, a front porch of 20, a sync width of 8 and a back porch of 20. Vertically, 22 front-porch lines are followed by the sync-start line, the sync-end line and 20 back-porch lines.

Top module: `dsi_video_seq`

## Requirements
- R1: Lane sequencing. While rst_ni is low, hs_valid_o and pix_rdy_o are 0. Every burst is preceded by exactly LP_GAP cycles (default 1) with hs_valid_o low, and that also holds after reset. hs_sot_o marks the first byte of a burst. hs_eot_o marks the last byte, and the cycle after it is low-power.
- R2: Packet headers. Every packet starts with a 4-byte header: data ID, then a 16-bit field low byte first, then the ECC. Bit p of the ECC (p=0..5) is the XOR of the 24 header bits under these masks, in order: F12CB7, F2555B, 749A6D, B8E38E, DF03F0, EFFC00 (hex). Header bit 0 is the LSB of the data ID. ECC bits 7:6 are 0. For a long packet the 16-bit field is the word count.
- R3: Long-packet checksum. A long packet ends with a CRC-16 over its payload, sent low byte first. The CRC uses the reflected polynomial 0x8408, is seeded with 0xFFFF, processes each byte LSB first and has no final XOR. An empty payload therefore gives 0xFFFF.
- R4: Active-line order. Each active line sends, in this order: front-porch filler, H-sync-start (short, ID 0x21, data 0x0000), sync-width blanking, H-sync-end (short, ID 0x31, data 0x0000), back-porch filler, then the pixel packet.
- R5: Pixel packet. The pixel packet has ID 0x3E, word count 3*h_act_i, and payload bytes pix_i[7:0], pix_i[15:8], pix_i[23:16] for each pixel. pix_rdy_o is high only in the cycle the first byte of a pixel goes out, and pix_i is taken in that cycle.
- R6: Filler sizing and type. Porch fillers use ID 0x09 when fill_blank_i=0 and ID 0x19 when fill_blank_i=1. The sync-width packet always uses ID 0x19. Each filler has word count max(0, 3*pixels-6) and an all-zero payload.
- R7: Active burst. All active lines of a frame form one continuous burst, with no low-power cycle between lines.
- R8: Vertical interval. The frame opens with v_fp_i lines that carry H-sync-start. Next comes one line with V-sync-start (ID 0x01) in that position, then one line with V-sync-end (ID 0x11), then v_bp_i H-sync-start lines. Each of these lines is a separate burst: sync packet, sync-width blanking, H-sync-end.
- R9: End-of-transmission. With eot_en_i=1, every burst ends with a short packet of ID 0x08 and data 0x0F0F. With eot_en_i=0, a vertical burst ends on its H-sync-end and the active burst ends on its last pixel packet CRC.
- R10: Vertical front-porch fill. With vfp_fill_i=1, each vertical-interval burst starts with a front-porch filler sized from h_fp_i. With vfp_fill_i=0 it starts directly with the sync packet.
- R11: Frame repetition. After the last active line, the sequence restarts with the first vertical front-porch line, so every frame carries the same number of bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_act_i | input | H_W | Active pixels per line |
| h_fp_i | input | H_W | Horizontal front porch, pixels |
| h_sw_i | input | H_W | Horizontal sync width, pixels |
| h_bp_i | input | H_W | Horizontal back porch, pixels |
| v_fp_i | input | V_W | Vertical front-porch lines |
| v_bp_i | input | V_W | Vertical back-porch lines |
| v_act_i | input | V_W | Active lines |
| fill_blank_i | input | 1 | Porch filler type: 0 null, 1 blanking |
| eot_en_i | input | 1 | Append end-of-transmission packet to bursts |
| vfp_fill_i | input | 1 | Front-porch filler in vertical bursts |
| pix_i | input | 24 | Pixel data |
| pix_rdy_o | output | 1 | Pixel taken this cycle |
| hs_data_o | output | 8 | Byte to serializer |
| hs_valid_o | output | 1 | Lane in high-speed mode, byte valid |
| hs_sot_o | output | 1 | First byte of burst |
| hs_eot_o | output | 1 | Last byte of burst |

## Verification
The end-of-burst strobe must fall in the same cycle as the final byte of whichever packet closes the burst. That is the second CRC byte of the last pixel packet, the ECC of an H-sync-end or the ECC of the end-of-transmission packet. In that same cycle the lane decision for the next cycle must also be made. Running all four combinations of the end-of-transmission and vertical-fill controls, with zero-length and non-zero fillers, moves this coincidence across every packet kind. A behavioural reference stream, built as queues from the requirements, is compared every cycle against the strobes, valid, data byte and pixel fetch.

// File: rtl/dsi_seq_pkg.sv
`timescale 1ns/1ps
package dsi_seq_pkg;
  localparam logic [7:0] DI_VSS   = 8'h01;
  localparam logic [7:0] DI_EOT   = 8'h08;
  localparam logic [7:0] DI_NULL  = 8'h09;
  localparam logic [7:0] DI_VSE   = 8'h11;
  localparam logic [7:0] DI_BLANK = 8'h19;
  localparam logic [7:0] DI_HSS   = 8'h21;
  localparam logic [7:0] DI_HSE   = 8'h31;
  localparam logic [7:0] DI_RGB24 = 8'h3E;

  typedef enum logic [2:0] {
    STP_FP, STP_SYNC, STP_BLANK, STP_HSE, STP_BP, STP_PIX, STP_EOT
  } step_e;

  typedef enum logic [1:0] {E_LP, E_HDR, E_PAY, E_CRC} eng_st_e;

  typedef struct packed {
    logic [7:0]  di;
    logic [15:0] wc;
    logic        is_long;
    logic        is_pix;
    logic        last;
  } pkt_desc_t;

  localparam logic [23:0] ECC_MASK [6] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  function automatic logic [7:0] hdr_ecc(input logic [23:0] h);
    logic [7:0] e;
    e = '0;
    for (int p = 0; p < 6; p++) e[p] = ^(h & ECC_MASK[p]);
    return e;
  endfunction
endpackage

// File: rtl/dsi_crc16.sv
`timescale 1ns/1ps
module dsi_crc16 (
  input  logic [15:0] crc_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  always_comb begin
    logic [15:0] c;
    c = crc_i;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ byte_i[b]) c = (c >> 1) ^ 16'h8408;
      else                  c = c >> 1;
    end
    crc_o = c;
  end
endmodule

// File: rtl/dsi_line_sched.sv
`timescale 1ns/1ps
module dsi_line_sched
  import dsi_seq_pkg::*;
#(
  parameter int H_W = 16,
  parameter int V_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] h_act_i,
  input  logic [H_W-1:0] h_fp_i,
  input  logic [H_W-1:0] h_sw_i,
  input  logic [H_W-1:0] h_bp_i,
  input  logic [V_W-1:0] v_fp_i,
  input  logic [V_W-1:0] v_bp_i,
  input  logic [V_W-1:0] v_act_i,
  input  logic           fill_blank_i,
  input  logic           eot_en_i,
  input  logic           vfp_fill_i,
  input  logic           take_i,
  output pkt_desc_t      desc_o
);
  localparam int L_W = V_W + 2;
  localparam int B_W = H_W + 2;

  logic [L_W-1:0] line_q, vert_lines, total_lines;
  step_e          step_q, eff_step, nxt_step;
  logic           vert, last_line, line_end;
  logic [7:0]     sync_di, fill_di;

  function automatic logic [15:0] porch_wc(input logic [H_W-1:0] px);
    logic [B_W-1:0] b;
    b = B_W'(px) * B_W'(3);
    return (b > B_W'(6)) ? 16'(b - B_W'(6)) : 16'd0;
  endfunction

  assign vert_lines  = L_W'(v_fp_i) + L_W'(v_bp_i) + L_W'(2);
  assign total_lines = vert_lines + L_W'(v_act_i);
  assign vert        = line_q < vert_lines;
  assign last_line   = line_q == total_lines - L_W'(1);
  assign fill_di     = fill_blank_i ? DI_BLANK : DI_NULL;
  assign sync_di     = (line_q == L_W'(v_fp_i))           ? DI_VSS :
                       (line_q == L_W'(v_fp_i) + L_W'(1)) ? DI_VSE : DI_HSS;

  always_comb begin
    eff_step = (step_q == STP_FP && vert && !vfp_fill_i) ? STP_SYNC : step_q;
    desc_o   = '0;
    nxt_step = STP_FP;
    line_end = 1'b0;
    unique case (eff_step)
      STP_FP: begin
        desc_o.di = fill_di; desc_o.wc = porch_wc(h_fp_i); desc_o.is_long = 1'b1;
        nxt_step  = STP_SYNC;
      end
      STP_SYNC: begin
        desc_o.di = sync_di;
        nxt_step  = STP_BLANK;
      end
      STP_BLANK: begin
        desc_o.di = DI_BLANK; desc_o.wc = porch_wc(h_sw_i); desc_o.is_long = 1'b1;
        nxt_step  = STP_HSE;
      end
      STP_HSE: begin
        desc_o.di   = DI_HSE;
        desc_o.last = vert && !eot_en_i;
        if (!vert)         nxt_step = STP_BP;
        else if (eot_en_i) nxt_step = STP_EOT;
        else               line_end = 1'b1;
      end
      STP_BP: begin
        desc_o.di = fill_di; desc_o.wc = porch_wc(h_bp_i); desc_o.is_long = 1'b1;
        nxt_step  = STP_PIX;
      end
      STP_PIX: begin
        desc_o.di      = DI_RGB24;
        desc_o.wc      = 16'(B_W'(h_act_i) * B_W'(3));
        desc_o.is_long = 1'b1;
        desc_o.is_pix  = 1'b1;
        desc_o.last    = last_line && !eot_en_i;
        if (last_line && eot_en_i) nxt_step = STP_EOT;
        else                       line_end = 1'b1;
      end
      default: begin
        desc_o.di   = DI_EOT;
        desc_o.wc   = 16'h0F0F;
        desc_o.last = 1'b1;
        line_end    = 1'b1;
      end
    endcase
    if (line_end) nxt_step = STP_FP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STP_FP;
      line_q <= '0;
    end else if (take_i) begin
      step_q <= nxt_step;
      if (line_end) line_q <= last_line ? '0 : line_q + L_W'(1);
    end
  end

  // R11
  line_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q < total_lines);
  // R8
  vert_burst_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && vert && eff_step == STP_HSE && !eot_en_i) |-> desc_o.last);
endmodule

// File: rtl/dsi_pkt_engine.sv
`timescale 1ns/1ps
module dsi_pkt_engine
  import dsi_seq_pkg::*;
#(
  parameter int LP_GAP = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  pkt_desc_t   desc_i,
  input  logic [23:0] pix_i,
  output logic        take_o,
  output logic        pix_rdy_o,
  output logic [7:0]  hs_data_o,
  output logic        hs_valid_o,
  output logic        hs_sot_o,
  output logic        hs_eot_o
);
  localparam int G_W = (LP_GAP > 1) ? $clog2(LP_GAP) : 1;

  eng_st_e     st_q;
  pkt_desc_t   cur_q;
  logic [15:0] idx_q, crc_q, crc_nxt, hold_q;
  logic [1:0]  ph_q;
  logic [G_W-1:0] gap_q;
  logic        sot_q, pkt_end, gap_done;
  logic [7:0]  pay_byte, hdr_byte;

  always_comb begin
    unique case (idx_q[1:0])
      2'd0:    hdr_byte = cur_q.di;
      2'd1:    hdr_byte = cur_q.wc[7:0];
      2'd2:    hdr_byte = cur_q.wc[15:8];
      default: hdr_byte = hdr_ecc({cur_q.wc, cur_q.di});
    endcase
    if (!cur_q.is_pix)    pay_byte = 8'h00;
    else if (ph_q == 2'd0) pay_byte = pix_i[7:0];
    else if (ph_q == 2'd1) pay_byte = hold_q[7:0];
    else                   pay_byte = hold_q[15:8];
  end

  dsi_crc16 i_crc (.crc_i(crc_q), .byte_i(pay_byte), .crc_o(crc_nxt));

  assign pkt_end  = (st_q == E_HDR && idx_q == 16'd3 && !cur_q.is_long) ||
                    (st_q == E_CRC && idx_q == 16'd1);
  assign gap_done = st_q == E_LP && gap_q == G_W'(LP_GAP - 1);
  assign take_o   = gap_done || (pkt_end && !cur_q.last);

  assign hs_valid_o = st_q != E_LP;
  assign hs_sot_o   = st_q == E_HDR && idx_q == 16'd0 && sot_q;
  assign hs_eot_o   = pkt_end && cur_q.last;
  assign pix_rdy_o  = st_q == E_PAY && cur_q.is_pix && ph_q == 2'd0;

  always_comb begin
    unique case (st_q)
      E_HDR:   hs_data_o = hdr_byte;
      E_PAY:   hs_data_o = pay_byte;
      E_CRC:   hs_data_o = idx_q[0] ? crc_q[15:8] : crc_q[7:0];
      default: hs_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_LP;
      cur_q  <= '0;
      idx_q  <= '0;
      crc_q  <= 16'hFFFF;
      hold_q <= '0;
      ph_q   <= '0;
      gap_q  <= '0;
      sot_q  <= 1'b0;
    end else if (take_o) begin
      cur_q <= desc_i;
      idx_q <= '0;
      st_q  <= E_HDR;
      crc_q <= 16'hFFFF;
      ph_q  <= '0;
      sot_q <= st_q == E_LP;
    end else begin
      unique case (st_q)
        E_LP: gap_q <= gap_q + G_W'(1);
        E_HDR: begin
          idx_q <= idx_q + 16'd1;
          if (idx_q == 16'd3) begin
            idx_q <= '0;
            if (!cur_q.is_long)       begin st_q <= E_LP; gap_q <= '0; end
            else if (cur_q.wc == '0)  st_q <= E_CRC;
            else                      st_q <= E_PAY;
          end
        end
        E_PAY: begin
          crc_q <= crc_nxt;
          ph_q  <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
          if (ph_q == 2'd0) hold_q <= pix_i[23:8];
          if (idx_q == cur_q.wc - 16'd1) begin
            idx_q <= '0;
            st_q  <= E_CRC;
          end else begin
            idx_q <= idx_q + 16'd1;
          end
        end
        default: begin
          idx_q <= idx_q + 16'd1;
          if (idx_q == 16'd1) begin st_q <= E_LP; gap_q <= '0; end
        end
      endcase
    end
  end

  // R1
  eot_then_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_eot_o |=> !hs_valid_o);
  // R1
  sot_after_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_sot_o |-> !$past(hs_valid_o));
  // R1
  rise_is_sot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_valid_o) |-> hs_sot_o);
  // R5
  pix_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_rdy_o |-> (hs_valid_o && !hs_sot_o && !hs_eot_o));
endmodule

// File: rtl/dsi_video_seq.sv
`timescale 1ns/1ps
module dsi_video_seq
  import dsi_seq_pkg::*;
#(
  parameter int H_W    = 16,
  parameter int V_W    = 12,
  parameter int LP_GAP = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] h_act_i,
  input  logic [H_W-1:0] h_fp_i,
  input  logic [H_W-1:0] h_sw_i,
  input  logic [H_W-1:0] h_bp_i,
  input  logic [V_W-1:0] v_fp_i,
  input  logic [V_W-1:0] v_bp_i,
  input  logic [V_W-1:0] v_act_i,
  input  logic           fill_blank_i,
  input  logic           eot_en_i,
  input  logic           vfp_fill_i,
  input  logic [23:0]    pix_i,
  output logic           pix_rdy_o,
  output logic [7:0]     hs_data_o,
  output logic           hs_valid_o,
  output logic           hs_sot_o,
  output logic           hs_eot_o
);
  pkt_desc_t desc;
  logic      take;

  dsi_line_sched #(.H_W(H_W), .V_W(V_W)) i_sched (
    .clk_i, .rst_ni, .h_act_i, .h_fp_i, .h_sw_i, .h_bp_i,
    .v_fp_i, .v_bp_i, .v_act_i, .fill_blank_i, .eot_en_i, .vfp_fill_i,
    .take_i(take), .desc_o(desc)
  );

  dsi_pkt_engine #(.LP_GAP(LP_GAP)) i_eng (
    .clk_i, .rst_ni, .desc_i(desc), .pix_i, .take_o(take),
    .pix_rdy_o, .hs_data_o, .hs_valid_o, .hs_sot_o, .hs_eot_o
  );
endmodule

// File: tb/test_dsi_video_seq.sv
`timescale 1ns/1ps
module test_dsi_video_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] h_act, h_fp, h_sw, h_bp;
  logic [11:0] v_fp, v_bp, v_act;
  logic        fill_blank, eot_en, vfp_fill;
  logic [23:0] pix;
  logic        pix_rdy, hs_valid, hs_sot, hs_eot;
  logic [7:0]  hs_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dsi_video_seq i_dsi_video_seq (
    .clk_i(clk), .rst_ni, .h_act_i(h_act), .h_fp_i(h_fp), .h_sw_i(h_sw), .h_bp_i(h_bp),
    .v_fp_i(v_fp), .v_bp_i(v_bp), .v_act_i(v_act), .fill_blank_i(fill_blank),
    .eot_en_i(eot_en), .vfp_fill_i(vfp_fill), .pix_i(pix), .pix_rdy_o(pix_rdy),
    .hs_data_o(hs_data), .hs_valid_o(hs_valid), .hs_sot_o(hs_sot), .hs_eot_o(hs_eot)
  );

  // expected per-cycle stream
  bit    e_v[$], e_s[$], e_e[$], e_p[$];
  byte   e_d[$];
  string e_t[$], e_bt[$];
  // burst under construction
  byte   b_d[$];
  bit    b_p[$];
  string b_t[$];
  int    mpix, bursts;

  function automatic logic [23:0] pixval(input int n);
    logic [7:0] b = n[7:0];
    return {b ^ 8'h5A, b + 8'h33, b};
  endfunction

  function automatic byte ecc_of(input logic [23:0] h);
    logic [23:0] m [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D,
                           24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
    byte e = 0;
    for (int p = 0; p < 6; p++) e[p] = ^(h & m[p]);
    return e;
  endfunction

  function automatic int pwc(input int px);
    return (px * 3 > 6) ? px * 3 - 6 : 0;
  endfunction

  task automatic put(input byte d, input bit p, input string t);
    b_d.push_back(d); b_p.push_back(p); b_t.push_back(t);
  endtask

  task automatic add_short(input byte di, input byte d0, input byte d1, input string t);
    put(di, 0, t); put(d0, 0, t); put(d1, 0, t);
    put(ecc_of({d1, d0, di}), 0, "R2");
  endtask

  task automatic add_long(input byte di, input int wc, input bit is_pix, input string t);
    logic [15:0] crc = 16'hFFFF;
    logic [23:0] pv = '0;
    byte d;
    put(di, 0, t); put(wc[7:0], 0, t); put(wc[15:8], 0, t);
    put(ecc_of({wc[15:0], di}), 0, "R2");
    for (int k = 0; k < wc; k++) begin
      if (is_pix && k % 3 == 0) begin pv = pixval(mpix); mpix++; end
      d = is_pix ? pv[8*(k%3) +: 8] : 8'h00;
      put(d, is_pix && (k % 3 == 0), t);
      for (int b = 0; b < 8; b++)
        crc = (crc[0] ^ d[b]) ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
    end
    put(crc[7:0], 0, "R3"); put(crc[15:8], 0, "R3");
  endtask

  task automatic flush(input string bt);
    e_v.push_back(0); e_s.push_back(0); e_e.push_back(0); e_p.push_back(0);
    e_d.push_back(0); e_t.push_back("R1"); e_bt.push_back("R1");
    for (int k = 0; k < b_d.size(); k++) begin
      e_v.push_back(1); e_s.push_back(k == 0); e_e.push_back(k == b_d.size() - 1);
      e_p.push_back(b_p[k]); e_d.push_back(b_d[k]); e_t.push_back(b_t[k]);
      e_bt.push_back(bt);
    end
    b_d.delete(); b_p.delete(); b_t.delete();
    bursts++;
  endtask

  task automatic model_frame();
    byte fdi = fill_blank ? 8'h19 : 8'h09;
    byte sdi;
    for (int l = 0; l < v_fp + 2 + v_bp; l++) begin
      sdi = (l == v_fp) ? 8'h01 : (l == v_fp + 1) ? 8'h11 : 8'h21;
      if (vfp_fill) add_long(fdi, pwc(h_fp), 0, "R10");
      add_short(sdi, 0, 0, "R8");
      add_long(8'h19, pwc(h_sw), 0, "R6");
      add_short(8'h31, 0, 0, "R8");
      if (eot_en) add_short(8'h08, 8'h0F, 8'h0F, "R9");
      flush("R8");
    end
    for (int l = 0; l < v_act; l++) begin
      add_long(fdi, pwc(h_fp), 0, "R6");
      add_short(8'h21, 0, 0, "R4");
      add_long(8'h19, pwc(h_sw), 0, "R6");
      add_short(8'h31, 0, 0, "R4");
      add_long(fdi, pwc(h_bp), 0, "R6");
      add_long(8'h3E, 3 * h_act, 1, "R5");
    end
    if (eot_en) add_short(8'h08, 8'h0F, 8'h0F, "R9");
    flush("R7");
  endtask

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int ha, input int hf, input int hs, input int hb,
                         input int vf, input int vb, input int va,
                         input bit fb, input bit eo, input bit vff, input int frames);
    int pix_cnt = 0, sot_seen = 0;
    bit took = 0;
    @(negedge clk);
    rst_ni = 0;
    h_act = 16'(ha); h_fp = 16'(hf); h_sw = 16'(hs); h_bp = 16'(hb);
    v_fp = 12'(vf); v_bp = 12'(vb); v_act = 12'(va);
    fill_blank = fb; eot_en = eo; vfp_fill = vff; pix = '0;
    repeat (2) @(negedge clk);
    chk(!hs_valid && !pix_rdy && !hs_sot && !hs_eot, "R1", "reset outputs",
        {hs_valid, pix_rdy, hs_sot, hs_eot}, 0);
    e_v.delete(); e_s.delete(); e_e.delete(); e_p.delete(); e_d.delete();
    e_t.delete(); e_bt.delete();
    mpix = 0; bursts = 0;
    for (int f = 0; f < frames; f++) model_frame();
    rst_ni = 1;
    for (int i = 0; i < e_v.size(); i++) begin
      if (took) pix_cnt++;
      pix = pixval(pix_cnt);
      #1;
      chk(hs_valid == e_v[i], e_bt[i], "valid", hs_valid, e_v[i]);
      chk(hs_sot == e_s[i], (e_s[i] || hs_sot) ? "R1" : e_bt[i], "sot", hs_sot, e_s[i]);
      chk(hs_eot == e_e[i], (e_e[i] || hs_eot) ? "R9" : e_bt[i], "eot", hs_eot, e_e[i]);
      chk(pix_rdy == e_p[i], "R5", "pix_rdy", pix_rdy, e_p[i]);
      if (e_v[i]) chk(hs_data == e_d[i], e_t[i], "data", hs_data, e_d[i]);
      if (hs_sot) sot_seen++;
      took = pix_rdy;
      @(negedge clk);
    end
    // R11: each frame repeats with the same burst count
    chk(sot_seen == bursts, "R11", "burst count", sot_seen, bursts);
  endtask

  initial begin
    // R4 R5 R6 R8 R9 R10: null fill, EoT on, vertical fill on
    run_cfg(4, 3, 2, 4, 2, 2, 3, 0, 1, 1, 2);
    // R7 R9 R10: blanking fill, EoT off, no vertical fill, zero-length fillers
    run_cfg(5, 2, 1, 1, 1, 1, 2, 1, 0, 0, 2);
    // R3 R6: null fill, EoT off, vertical fill on
    run_cfg(3, 5, 4, 3, 3, 2, 2, 0, 0, 1, 2);
    // R2 R8 R11: blanking fill, EoT on, no vertical fill
    run_cfg(6, 4, 3, 2, 2, 1, 2, 1, 1, 0, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule